// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer

This block sits behind the serial front end of a byte-serial EEPROM model. It gathers the data bytes of a single write transaction into a small page buffer, then commits them to the storage array in one timed internal write cycle. The serial shifter that feeds it supplies four things: the starting address once the address phase ends, a strobe for each finished data byte, a one-cycle indication that chip select went high, and whether that rise landed on a byte boundary. The block also takes the current write-enable latch state and the write-protect level.

The page buffer is indexed by the low address bits. Incoming bytes advance that index and wrap around within the page. The upper address bits are captured when the transaction starts and do not change while it lasts. A per-location mask records which buffer slots were filled. During the write cycle only those slots are copied to the array, one per clock. The busy flag stays high for a fixed, parameterized number of clocks. In the last busy clock the block pulses a request to clear the write-enable latch.

Top module: `ewb_page_writer`

## Requirements
- R1: After a start strobe, the first data byte goes to page offset start_addr[3:0], and each later byte goes to the next offset.
- R2: The offset wraps from 15 to 0 inside the same page, and a later byte overwrites a slot filled earlier in the same transaction.
- R3: Every array write of a transaction uses upper address bits start_addr[10:4] as captured at the start strobe.
- R4: A write cycle starts only when cs_rise arrives with bit_aligned high. A cs_rise with bit_aligned low discards the transaction, so no array write happens and wip stays low.
- R5: A cs_rise before any data byte has been received starts no write cycle and gives no wel_clr pulse.
- R6: A write cycle starts only if wel is 1 and wp is 1 in the cs_rise cycle. Otherwise the transaction is discarded.
- R7: The array receives exactly one write for each distinct page slot received (min(n,16) writes for n bytes). Page locations that were not received keep their old contents.
- R8: wip rises in the clock after the committing cs_rise and stays high for exactly WRITE_CYCLES clocks. All array writes happen while wip is high.
- R9: wel_clr is a single-clock pulse in the last clock of wip, once per write cycle.
- R10: A data byte strobed in the same clock as cs_rise belongs to the transaction. It counts as a received byte and is written.
- R11: While wip is high, start, byte and cs_rise strobes are ignored.
- R12: After reset, wip, wel_clr and mem_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Pulse: write command and address received |
| start_addr | input | ADDR_W | Starting byte address of the transaction |
| byte_valid | input | 1 | Pulse: one data byte complete |
| byte_data | input | 8 | Data byte accompanying byte_valid |
| cs_rise | input | 1 | Pulse: chip select went high |
| bit_aligned | input | 1 | High when the received bit count is a whole number of bytes |
| wel | input | 1 | Write-enable latch state |
| wp | input | 1 | Write-protect pin level, high allows writing |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| wip | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | Pulse requesting the write-enable latch be cleared |

## Verification
The case most likely to break is the final data byte and the cs_rise indication arriving in the same clock. The byte must be stored, and it must also count toward the one-byte minimum for a commit. The bench provokes this on every odd-length transaction of the sweep, including a single-byte transaction where that byte alone must start the write. It judges the result by comparing the whole page in its array model, and the number of array writes, against values worked out from offset and length. A second overlap drives strobes into a write cycle that is already running; the bench checks that the busy length and the write count do not change.

// File: rtl/ewb_pkg.sv
package ewb_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_BUSY    = 2'd2
    } wr_state_e;
endpackage

// File: rtl/ewb_page_store.sv
module ewb_page_store
    import ewb_pkg::*;
#(
    parameter int PAGE_BITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 we,
    input  logic [PAGE_BITS-1:0] widx,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [PAGE_BITS-1:0] ridx,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rvalid
);
    localparam int PAGE = 1 << PAGE_BITS;

    typedef struct packed {
        logic [PAGE-1:0][DATA_W-1:0] data;
        logic [PAGE-1:0]             mask;
    } store_t;

    store_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.mask = '0;
        end else if (we) begin
            st_d.data[widx] = wdata;
            st_d.mask[widx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata  = st_q.data[ridx];
    assign rvalid = st_q.mask[ridx];

    // a clear leaves no slot marked as received
    assert_mask_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.mask == '0));
endmodule

// File: rtl/ewb_write_timer.sv
module ewb_write_timer #(
    parameter int WRITE_CYCLES = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    output logic [$clog2(WRITE_CYCLES+1)-1:0] cnt,
    output logic                          last
);
    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!run)      cnt_d = '0;
        else if (last) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = run && (cnt_q == CW'(WRITE_CYCLES - 1));
    assign cnt  = cnt_q;

    assert_timer_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < WRITE_CYCLES);
endmodule

// File: rtl/ewb_page_writer.sv
module ewb_page_writer
    import ewb_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int PAGE_BITS    = 4,
    parameter int WRITE_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              bit_aligned,
    input  logic              wel,
    input  logic              wp,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              wip,
    output logic              wel_clr
);
    localparam int PAGE   = 1 << PAGE_BITS;
    localparam int BASE_W = ADDR_W - PAGE_BITS;
    localparam int CW     = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        wr_state_e            st;
        logic [BASE_W-1:0]    base;
        logic [PAGE_BITS-1:0] ptr;
        logic                 got;
    } ctl_t;

    ctl_t q, d;

    logic                 buf_clr, buf_we;
    logic [PAGE_BITS-1:0] rd_idx;
    logic [DATA_W-1:0]    rd_data;
    logic                 rd_valid;
    logic [CW-1:0]        tmr_cnt;
    logic                 tmr_last;
    logic                 busy;
    logic                 drain;

    assign busy = (q.st == ST_BUSY);

    always_comb begin
        d       = q;
        buf_clr = 1'b0;
        buf_we  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_valid) begin
                    d.st    = ST_COLLECT;
                    d.base  = start_addr[ADDR_W-1:PAGE_BITS];
                    d.ptr   = start_addr[PAGE_BITS-1:0];
                    d.got   = 1'b0;
                    buf_clr = 1'b1;
                end
            end
            ST_COLLECT: begin
                if (byte_valid) begin
                    buf_we = 1'b1;
                    d.ptr  = q.ptr + 1'b1;
                    d.got  = 1'b1;
                end
                if (cs_rise) begin
                    if (bit_aligned && (q.got || byte_valid) && wel && wp)
                        d.st = ST_BUSY;
                    else
                        d.st = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (tmr_last) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, base: '0, ptr: '0, got: 1'b0};
        else        q <= d;
    end

    ewb_page_store #(.PAGE_BITS(PAGE_BITS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (buf_clr),
        .we     (buf_we),
        .widx   (q.ptr),
        .wdata  (byte_data),
        .ridx   (rd_idx),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    ewb_write_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .cnt   (tmr_cnt),
        .last  (tmr_last)
    );

    assign rd_idx    = tmr_cnt[PAGE_BITS-1:0];
    assign drain     = busy && (int'(tmr_cnt) < PAGE);
    assign mem_we    = drain && rd_valid;
    assign mem_addr  = {q.base, rd_idx};
    assign mem_wdata = rd_data;
    assign wip       = busy;
    assign wel_clr   = busy && tmr_last;

    assert_we_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);

    assert_wip_needs_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(cs_rise && bit_aligned && wel && wp));

    assert_clr_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wip);

    assert_clr_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> wip);

    assert_base_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && $past(wip)) |-> $stable(mem_addr[ADDR_W-1:PAGE_BITS]));
endmodule

// File: tb/ewb_page_writer_tb.sv
`timescale 1ns/1ps
module ewb_page_writer_tb;
    localparam int ADDR_W = 11;
    localparam int WCYC   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_valid = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              cs_rise = 1'b0;
    logic              bit_aligned = 1'b0;
    logic              wel = 1'b1;
    logic              wp = 1'b1;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              wip;
    logic              wel_clr;

    always #2 clk = ~clk;

    ewb_page_writer #(.ADDR_W(ADDR_W), .PAGE_BITS(4), .WRITE_CYCLES(WCYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .bit_aligned(bit_aligned), .wel(wel), .wp(wp), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wip(wip), .wel_clr(wel_clr)
    );

    logic [7:0] ram [0:2047];
    logic [7:0] expm[0:2047];
    int checks = 0, fails = 0;
    int wip_cnt = 0, clr_cnt = 0, we_cnt = 0, bad_base = 0;
    int cur_base = 0;

    always @(negedge clk) begin
        if (wip) wip_cnt++;
        if (wel_clr) clr_cnt++;
        if (mem_we) begin
            ram[mem_addr] = mem_wdata;
            we_cnt++;
            if (int'(mem_addr[10:4]) != cur_base) bad_base++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int off, input int n, input int k);
        return 8'((off * 37 + n * 11 + k * 5 + 1) & 255);
    endfunction

    task automatic txn(input int base, input int off, input int n, input bit aligned,
                       input bit w_el, input bit w_p, input bit same, input string tag);
        bit commit;
        int mism;
        int distinct;
        commit   = aligned && (n > 0) && w_el && w_p;
        distinct = (n > 16) ? 16 : n;
        wip_cnt = 0; clr_cnt = 0; we_cnt = 0; bad_base = 0; cur_base = base;
        wel = w_el; wp = w_p;
        start_valid = 1'b1; start_addr = ADDR_W'(base * 16 + off);
        @(negedge clk);
        start_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_valid = 1'b1; byte_data = dval(off, n, k);
            if (same && k == n - 1) begin cs_rise = 1'b1; bit_aligned = aligned; end
            @(negedge clk);
            byte_valid = 1'b0; cs_rise = 1'b0;
        end
        if (!(same && n > 0)) begin
            cs_rise = 1'b1; bit_aligned = aligned;
            @(negedge clk);
            cs_rise = 1'b0;
        end
        if (commit)
            for (int k = 0; k < n; k++) expm[base * 16 + ((off + k) & 15)] = dval(off, n, k);
        repeat (WCYC + 4) @(negedge clk);
        mism = 0;
        for (int i = 0; i < 16; i++) if (ram[base * 16 + i] !== expm[base * 16 + i]) mism++;
        chk(mism == 0, {tag, " R1 R2 R7 page contents mismatching bytes"}, mism, 0);
        chk(we_cnt == (commit ? distinct : 0), {tag, " R7 array write count"}, we_cnt,
            commit ? distinct : 0);
        chk(wip_cnt == (commit ? WCYC : 0), {tag, " R8 wip length"}, wip_cnt, commit ? WCYC : 0);
        chk(clr_cnt == (commit ? 1 : 0), {tag, " R9 wel_clr pulses"}, clr_cnt, commit ? 1 : 0);
        chk(bad_base == 0, {tag, " R3 writes outside page"}, bad_base, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) begin
            ram[i] = 8'(i ^ 8'h5A);
            expm[i] = 8'(i ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        chk(wip == 1'b0, "R12 wip after reset", int'(wip), 0);
        chk(wel_clr == 1'b0, "R12 wel_clr after reset", int'(wel_clr), 0);
        chk(mem_we == 1'b0, "R12 mem_we after reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: offsets x lengths, odd lengths end with byte and cs_rise together (R10)
        for (int off = 0; off < 16; off++)
            for (int n = 0; n <= 20; n++)
                txn((off * 5 + n * 3) % 128, off, n, 1'b1, 1'b1, 1'b1, n % 2 == 1,
                    (n == 0) ? "R5" : ((n % 2 == 1) ? "R10" : "R1"));

        // misaligned CS rise discards (R4)
        for (int n = 1; n <= 17; n += 4) txn(100 + n, 3, n, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        txn(120, 9, 5, 1'b0, 1'b1, 1'b1, 1'b1, "R4");
        // write-enable and protect gating (R6)
        txn(60, 2, 4, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        txn(61, 7, 4, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        txn(62, 0, 18, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        // single byte arriving with cs_rise commits alone (R10)
        txn(63, 15, 1, 1'b1, 1'b1, 1'b1, 1'b1, "R10");

        // strobes during busy are ignored (R11)
        wip_cnt = 0; clr_cnt = 0; we_cnt = 0; bad_base = 0; cur_base = 70;
        wel = 1'b1; wp = 1'b1;
        start_valid = 1'b1; start_addr = ADDR_W'(70 * 16 + 4);
        @(negedge clk); start_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1'b1; byte_data = 8'(k + 200);
            @(negedge clk); byte_valid = 1'b0;
            expm[70 * 16 + 4 + k] = 8'(k + 200);
        end
        cs_rise = 1'b1; bit_aligned = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
        repeat (2) @(negedge clk);
        start_valid = 1'b1; start_addr = ADDR_W'(71 * 16);
        @(negedge clk); start_valid = 1'b0;
        byte_valid = 1'b1; byte_data = 8'hEE;
        @(negedge clk); byte_valid = 1'b0;
        cs_rise = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
        repeat (WCYC + 6) @(negedge clk);
        chk(wip_cnt == WCYC, "R11 wip length with strobes during busy", wip_cnt, WCYC);
        chk(we_cnt == 3, "R11 write count with strobes during busy", we_cnt, 3);
        chk(ram[71 * 16] === expm[71 * 16], "R11 neighbouring page untouched",
            int'(ram[71 * 16]), int'(expm[71 * 16]));
        chk(ram[70 * 16 + 5] === 8'd201, "R11 committed byte", int'(ram[70 * 16 + 5]), 201);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule